// File: doc/BRIEF.md
# 1-Wire Search Triplet Engine

This block performs a single branch step of the 1-Wire ROM search in hardware. After a start pulse it asks a bus bit-slot engine for two read slots: the first returns the ID bit of the current search position, the second returns its complement. From the pair it decides which branch to follow. The branch is either the preferred direction given at start, when the bits show a discrepancy, or the direction forced by the responding devices. It then asks for one write slot that sends the chosen direction bit back onto the bus.

The step ends with a one-cycle done pulse and a registered 3-bit result code. A search controller above this block repeats the step 64 times and keeps the ROM value and CRC. Slot transfers use a level request with a one-cycle acknowledge. A transfer that is not acknowledged within a fixed number of cycles aborts the step.

Top module: `triplet_engine`

## Requirements
- R1: A start pulse while idle raises busy_o on the next cycle and issues, in order, a read slot (slot_wr_o=0), a second read slot (slot_wr_o=0) and a write slot (slot_wr_o=1). Each slot request is held until slot_ack_i is seen.
- R2: When both read bits are 1, the result is 3'b011 and no write slot is issued.
- R3: When both read bits are 0, the direction is the preference sampled at start. The written bit equals that preference and the result is 3'b100 for preference 1 and 3'b000 for preference 0.
- R4: When exactly one read bit is 0, the direction is forced to the ID bit. The written bit equals the ID bit and the result is 3'b101 (ID bit 1) or 3'b010 (ID bit 0).
- R5: Only bit 0 of slot_rdata_i is used. The other bits have no effect on the result.
- R6: A slot request not acknowledged within TMO_LIMIT cycles of being raised aborts the step with result 3'b011 and no further slot. An acknowledge in the last allowed cycle is still accepted.
- R7: done_o is high for exactly one cycle and busy_o is low in that cycle. result_o takes its new value in the same cycle and holds it until the next done.
- R8: A start pulse while busy is ignored, including its preference input.
- R9: After reset, busy_o, done_o and slot_req_o are 0 and result_o is 3'b000.
- Result code layout: bit 2 = direction taken, bit 1 = complement bit, bit 0 = ID bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one search step (pulse) |
| dir_pref_i | input | 1 | Preferred direction if both values are present |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle end-of-step pulse |
| result_o | output | 3 | Result code {dir, complement, id} |
| slot_req_o | output | 1 | Bit-slot request, held until acknowledged |
| slot_wr_o | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit_o | output | 1 | Bit to send in a write slot |
| slot_ack_i | input | 1 | Slot complete (one cycle) |
| slot_rdata_i | input | RX_W | Received slot value; only bit 0 used |

## Verification
The slot acknowledge and the expiry of the slot timeout can fall in the same cycle. The bench provokes this by delaying an acknowledge by exactly TMO_LIMIT-1 cycles after the request rises, and it judges the step by the normal result code and the write slot that follows. A delay of TMO_LIMIT cycles must instead produce 3'b011 with no further slot. A start pulse that lands in the same cycle as an acknowledge is also applied, with the opposite preference, and must leave the chosen direction unchanged.

// File: rtl/triplet_pkg.sv
package triplet_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_ID  = 2'd1,
        ST_RD_CMP = 2'd2,
        ST_WR_DIR = 2'd3
    } trip_state_e;

    localparam logic [2:0] CODE_NONE  = 3'b011;
    localparam logic [2:0] CODE_RESET = 3'b000;

    typedef struct packed {
        trip_state_e st;
        logic        id_bit;
        logic        cmp_bit;
        logic        dir;
        logic        pref;
        logic        done;
        logic [2:0]  res;
    } trip_regs_t;

endpackage

// File: rtl/triplet_decide.sv
module triplet_decide (
    input  logic       id_i,
    input  logic       cmp_i,
    input  logic       pref_i,
    output logic       none_o,
    output logic       dir_o,
    output logic [2:0] code_o
);
    always_comb begin
        none_o = id_i & cmp_i;
        if (!id_i && !cmp_i) begin
            dir_o = pref_i;
        end else begin
            dir_o = id_i;
        end
        if (none_o) begin
            code_o = triplet_pkg::CODE_NONE;
        end else begin
            code_o = {dir_o, cmp_i, id_i};
        end
    end
endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clear_i,
    output logic expire_o
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i || clear_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
        expire_o = run_i && (cnt_q == LAST);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_TIMER_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/triplet_engine.sv
module triplet_engine #(
    parameter int RX_W      = 8,
    parameter int TMO_LIMIT = 64
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            dir_pref_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [2:0]      result_o,
    output logic            slot_req_o,
    output logic            slot_wr_o,
    output logic            slot_wbit_o,
    input  logic            slot_ack_i,
    input  logic [RX_W-1:0] slot_rdata_i
);
    import triplet_pkg::*;

    trip_regs_t r_d, r_q;
    logic       in_slot;
    logic       rx_bit;
    logic       expire;
    logic       dec_none;
    logic       dec_dir;
    logic [2:0] dec_code;

    assign in_slot = (r_q.st != ST_IDLE);
    assign rx_bit  = slot_rdata_i[0];

    slot_timer #(.LIMIT(TMO_LIMIT)) i_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (in_slot),
        .clear_i (slot_ack_i),
        .expire_o(expire)
    );

    triplet_decide i_decide (
        .id_i  (r_q.id_bit),
        .cmp_i (rx_bit),
        .pref_i(r_q.pref),
        .none_o(dec_none),
        .dir_o (dec_dir),
        .code_o(dec_code)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_RD_ID;
                    r_d.pref = dir_pref_i;
                end
            end
            ST_RD_ID: begin
                if (slot_ack_i) begin
                    r_d.id_bit = rx_bit;
                    r_d.st     = ST_RD_CMP;
                end else if (expire) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.res  = CODE_NONE;
                end
            end
            ST_RD_CMP: begin
                if (slot_ack_i) begin
                    r_d.cmp_bit = rx_bit;
                    if (dec_none) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.res  = dec_code;
                    end else begin
                        r_d.dir = dec_dir;
                        r_d.st  = ST_WR_DIR;
                    end
                end else if (expire) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.res  = CODE_NONE;
                end
            end
            ST_WR_DIR: begin
                if (slot_ack_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.res  = {r_q.dir, r_q.cmp_bit, r_q.id_bit};
                end else if (expire) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.res  = CODE_NONE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, id_bit: 1'b0, cmp_bit: 1'b0, dir: 1'b0,
                     pref: 1'b0, done: 1'b0, res: CODE_RESET};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = in_slot;
    assign done_o      = r_q.done;
    assign result_o    = r_q.res;
    assign slot_req_o  = in_slot;
    assign slot_wr_o   = (r_q.st == ST_WR_DIR);
    assign slot_wbit_o = r_q.dir;

    AST_START_OPENS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !busy_o |=> busy_o && slot_req_o && !slot_wr_o); // R1
    AST_NONE_NO_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && (result_o[1:0] == 2'b11) |-> !result_o[2]); // R2
    AST_BOTH_ZERO_PREF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && (result_o[1:0] == 2'b00) |-> (result_o[2] == r_q.pref)); // R3
    AST_WBIT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_wr_o && $past(slot_wr_o) |-> $stable(slot_wbit_o)); // R3
    AST_FORCED_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && (result_o[0] != result_o[1]) |-> (result_o[2] == result_o[0])); // R4
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R7
    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o && !slot_req_o); // R7
    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o && $past(!done_o) |-> $stable(result_o)); // R7
    AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && start_i |=> $stable(r_q.pref)); // R8
endmodule

// File: tb/test_triplet_engine.sv
`timescale 1ns/1ps
module test_triplet_engine;
    localparam int RX_W  = 8;
    localparam int LIMIT = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            pref = 1'b0;
    logic            busy, done, req, wr, wbit;
    logic [2:0]      result;
    logic            ack = 1'b0;
    logic [RX_W-1:0] rdata = '0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    triplet_engine #(.RX_W(RX_W), .TMO_LIMIT(LIMIT)) i_triplet_engine (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_pref_i(pref),
        .busy_o(busy), .done_o(done), .result_o(result),
        .slot_req_o(req), .slot_wr_o(wr), .slot_wbit_o(wbit),
        .slot_ack_i(ack), .slot_rdata_i(rdata)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_code(bit p, bit idb, bit cmpb);
        if (idb && cmpb) return 3'b011;
        if (!idb && !cmpb) return p ? 3'b100 : 3'b000;
        return idb ? 3'b101 : 3'b010;
    endfunction

    task automatic do_step(input bit p, input bit idb, input bit cmpb,
                           input int lat0, input int lat1, input int lat2,
                           input bit poke, input logic [RX_W-1:0] junk,
                           input string tag_in);
        logic [2:0] exp;
        bit         skip;
        int         lats [3];
        bit         bits [2];
        string      tag;
        exp  = exp_code(p, idb, cmpb);
        skip = idb && cmpb;
        lats = '{lat0, lat1, lat2};
        bits = '{idb, cmpb};
        if (tag_in != "") tag = tag_in;
        else if (skip) tag = "R2";
        else if (idb == cmpb) tag = "R3";
        else tag = "R4";

        @(negedge clk);
        start = 1'b1;
        pref  = p;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", busy, 1);
        for (int s = 0; s < 3; s++) begin
            if (s == 2 && skip) break;
            chk(req == 1'b1, "R1 slot request", req, 1);
            chk(wr == (s == 2), "R1 slot order", wr, (s == 2));
            if (lats[s] >= LIMIT) begin
                repeat (LIMIT) @(negedge clk);
                exp = 3'b011;
                tag = "R6";
                break;
            end
            repeat (lats[s]) @(negedge clk);
            chk(req == 1'b1, "R6 request held while waiting", req, 1);
            ack   = 1'b1;
            rdata = junk;
            if (s < 2) rdata[0] = bits[s];
            if (s == 2) chk(wbit == exp[2], {tag, " written bit"}, wbit, exp[2]);
            if (poke && s == 0) begin
                start = 1'b1;
                pref  = ~p;
            end
            @(negedge clk);
            ack   = 1'b0;
            start = 1'b0;
        end
        chk(done == 1'b1, {tag, " done pulse"}, done, 1);
        chk(result == exp, {tag, " result"}, result, exp);
        chk(busy == 1'b0 && req == 1'b0, "R7 idle at done, no extra slot", req, 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", done, 0);
        chk(req == 1'b0, "R2 no write slot after step", req, 0);
        chk(result == exp, "R7 result held", result, exp);
    endtask

    initial begin
        logic [RX_W-1:0] j;
        int l0, l1, l2;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9 reset busy", busy, 0);
        chk(done == 1'b0, "R9 reset done", done, 0);
        chk(req == 1'b0, "R9 reset req", req, 0);
        chk(result == 3'b000, "R9 reset result", result, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_step(1'b0, 1'b1, 1'b1, 0, 0, 0, 1'b0, '0, "");
        do_step(1'b1, 1'b0, 1'b0, 1, 2, 0, 1'b0, '0, "");
        do_step(1'b0, 1'b0, 1'b0, 0, 0, 3, 1'b0, '0, "");
        do_step(1'b0, 1'b1, 1'b0, 2, 0, 1, 1'b0, '0, "");
        do_step(1'b1, 1'b0, 1'b1, 0, 1, 0, 1'b0, '0, "");
        do_step(1'b1, 1'b0, 1'b0, 0, 0, 0, 1'b0, 8'hFE, "R5");
        do_step(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, 8'hAA, "R5");
        do_step(1'b1, 1'b0, 1'b0, LIMIT-1, LIMIT-1, LIMIT-1, 1'b0, '0, "R6 late ack");
        do_step(1'b1, 1'b0, 1'b0, LIMIT, 0, 0, 1'b0, '0, "");
        do_step(1'b1, 1'b0, 1'b1, 0, LIMIT, 0, 1'b0, '0, "");
        do_step(1'b1, 1'b0, 1'b0, 0, 0, LIMIT, 1'b0, '0, "");
        do_step(1'b0, 1'b0, 1'b0, 2, 0, 0, 1'b1, '0, "R8");
        do_step(1'b1, 1'b0, 1'b0, 0, 1, 0, 1'b1, '0, "R8");

        for (int n = 0; n < 300; n++) begin
            j  = RX_W'($urandom());
            l0 = (($urandom() % 16) == 0) ? LIMIT : int'($urandom() % LIMIT);
            l1 = int'($urandom() % LIMIT);
            l2 = int'($urandom() % LIMIT);
            do_step(1'($urandom()), 1'($urandom()), 1'($urandom()),
                    l0, l1, l2, 1'($urandom()), j, "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule